// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration fabric. It turns processor I/O accesses into configuration read and write requests. Two dword I/O ports are decoded. The address port at I/O address 0xCF8 holds a selector word. The data port at I/O address 0xCFC carries the data of the configuration access that the selector names.

The selector word has these fields: bit 31 is the enable, bits 23:16 the bus, bits 15:11 the device, bits 10:8 the function and bits 7:2 the dword register index. A data-port access with the enable set becomes exactly one request toward a configuration target. The request is marked local when the bus is zero and forwarded otherwise. The I/O side waits until the target responds. A read that no target claims returns all ones.

I/O accesses use a dword address. A sub-dword access to 0xCFC..0xCFF is expressed through the four byte enables, and those enables reach the target unchanged.

Top module: `cfg_port_bridge`

## Requirements
- R1: Reading the address port returns the stored selector word with bits 30:24 and 1:0 read as zero. After reset the word is zero, and it changes only on an address-port write.
- R2: An address-port write updates only the byte lanes whose byte enable is set. Byte enable bit k covers data bits 8k+7:8k.
- R3: A data-port access with selector bit 31 set issues one single-cycle request. The request carries bus = bits 23:16, device = 15:11, function = 10:8 and register = 7:2 of the selector. These fields stay stable until the response arrives.
- R4: cfg_type1_o is 0 for requests to bus 0 and 1 for any other bus.
- R5: A data-port write forwards the write data and the I/O byte enables on the request, and its completion returns zero read data. A data-port read returns cfg_rdata_i when the target claims it.
- R6: A data-port read that the target answers with cfg_claimed_i low completes with 0xFFFFFFFF.
- R7: With selector bit 31 clear, a data-port read completes with 0xFFFFFFFF, a data-port write is dropped, and neither issues a request.
- R8: Only one request is outstanding at a time. io_ready_o stays low from the request until the cycle after cfg_rsp_i, and then it is high for exactly one cycle.
- R9: An access to any other I/O dword completes in the cycle after it is presented. It reads 0xFFFFFFFF, and a write to it leaves the selector word unchanged.
- R10: After reset io_ready_o and cfg_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_req_i | input | 1 | I/O access present, held until io_ready_o |
| io_we_i | input | 1 | I/O access is a write |
| io_dw_addr_i | input | 14 | I/O dword address (byte address bits 15:2) |
| io_be_i | input | 4 | I/O byte enables |
| io_wdata_i | input | 32 | I/O write data |
| io_ready_o | output | 1 | One-cycle completion of the I/O access |
| io_rdata_o | output | 32 | Read data, valid with io_ready_o |
| cfg_req_o | output | 1 | Single-cycle configuration request strobe |
| cfg_type1_o | output | 1 | Request is forwarded (non-zero bus) |
| cfg_bus_o | output | 8 | Target bus |
| cfg_dev_o | output | 5 | Target device |
| cfg_fn_o | output | 3 | Target function |
| cfg_reg_o | output | 6 | Target dword register index |
| cfg_we_o | output | 1 | Request is a write |
| cfg_be_o | output | 4 | Request byte enables |
| cfg_wdata_o | output | 32 | Request write data |
| cfg_rsp_i | input | 1 | Response strobe from target |
| cfg_claimed_i | input | 1 | Target claimed the request |
| cfg_rdata_i | input | 32 | Read data from target |

## Verification
A corrupted selector word shows up at the next data-port access as wrong bus, device, function or register fields on the request. It also shows up at once on an address-port readback. A sequencer stuck in its wait state shows as io_ready_o never rising, so the access hangs. A sequencer that leaves the wait state early shows as a completion before cfg_rsp_i, or as a second request strobe while one is outstanding. A wrong completion mux shows in the first read after the fault: claimed data, all ones for master-abort, or zero for writes.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned BEW  = DW / 8;
  localparam int unsigned BUSW = 8;
  localparam int unsigned DEVW = 5;
  localparam int unsigned FNW  = 3;
  localparam int unsigned REGW = 6;
  localparam logic [DW-1:0] SEL_MASK = 32'h80FF_FFFC;
  localparam logic [DW-1:0] ALL_ONES = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} st_e;

  typedef struct packed {
    logic            en;
    logic [BUSW-1:0] bus;
    logic [DEVW-1:0] dev;
    logic [FNW-1:0]  fn;
    logic [REGW-1:0] reg_idx;
  } cfg_sel_t;

  function automatic cfg_sel_t decode_sel(logic [DW-1:0] w);
    cfg_sel_t s;
    s.en      = w[31];
    s.bus     = w[23:16];
    s.dev     = w[15:11];
    s.fn      = w[10:8];
    s.reg_idx = w[7:2];
    return s;
  endfunction
endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
  import cfg_port_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [BEW-1:0] be_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  word_o,
  output cfg_sel_t       sel_o
);
  logic [DW-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    for (int b = 0; b < BEW; b++)
      if (be_i[b]) word_d[b*8 +: 8] = wdata_i[b*8 +: 8];
    word_d = word_d & SEL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (wr_i) word_q <= word_d;
  end

  assign word_o = word_q;
  assign sel_o  = decode_sel(word_q);

  assert_sel_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(word_q));
endmodule

// File: rtl/cfg_port_fsm.sv
module cfg_port_fsm
  import cfg_port_pkg::*;
#(
  parameter int unsigned      IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_req_i,
  input  logic             io_we_i,
  input  logic [IO_AW-3:0] io_dw_addr_i,
  input  logic [BEW-1:0]   io_be_i,
  input  logic [DW-1:0]    io_wdata_i,
  output logic             io_ready_o,
  output logic [DW-1:0]    io_rdata_o,
  input  cfg_sel_t         sel_i,
  input  logic [DW-1:0]    sel_word_i,
  output logic             sel_wr_o,
  output logic             cfg_req_o,
  output logic             cfg_type1_o,
  output logic [BUSW-1:0]  cfg_bus_o,
  output logic [DEVW-1:0]  cfg_dev_o,
  output logic [FNW-1:0]   cfg_fn_o,
  output logic [REGW-1:0]  cfg_reg_o,
  output logic             cfg_we_o,
  output logic [BEW-1:0]   cfg_be_o,
  output logic [DW-1:0]    cfg_wdata_o,
  input  logic             cfg_rsp_i,
  input  logic             cfg_claimed_i,
  input  logic [DW-1:0]    cfg_rdata_i
);
  st_e state_q;
  logic [DW-1:0] rdata_q;
  logic hit_addr, hit_data;

  assign hit_addr = io_dw_addr_i == ADDR_PORT[IO_AW-1:2];
  assign hit_data = io_dw_addr_i == DATA_PORT[IO_AW-1:2];
  assign sel_wr_o = (state_q == ST_IDLE) && io_req_i && io_we_i && hit_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rdata_q     <= '0;
      cfg_req_o   <= 1'b0;
      cfg_type1_o <= 1'b0;
      cfg_bus_o   <= '0;
      cfg_dev_o   <= '0;
      cfg_fn_o    <= '0;
      cfg_reg_o   <= '0;
      cfg_we_o    <= 1'b0;
      cfg_be_o    <= '0;
      cfg_wdata_o <= '0;
    end else begin
      cfg_req_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (io_req_i) begin
          if (hit_data && sel_i.en) begin
            cfg_req_o   <= 1'b1;
            cfg_type1_o <= sel_i.bus != '0;
            cfg_bus_o   <= sel_i.bus;
            cfg_dev_o   <= sel_i.dev;
            cfg_fn_o    <= sel_i.fn;
            cfg_reg_o   <= sel_i.reg_idx;
            cfg_we_o    <= io_we_i;
            cfg_be_o    <= io_be_i;
            cfg_wdata_o <= io_wdata_i;
            state_q     <= ST_WAIT;
          end else begin
            // address port, disabled data port, or unclaimed I/O dword
            rdata_q <= io_we_i ? '0 : (hit_addr ? sel_word_i : ALL_ONES);
            state_q <= ST_DONE;
          end
        end
        ST_WAIT: if (cfg_rsp_i) begin
          rdata_q <= cfg_we_o ? '0 : (cfg_claimed_i ? cfg_rdata_i : ALL_ONES);
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign io_ready_o = state_q == ST_DONE;
  assign io_rdata_o = rdata_q;

  assert_req_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |=> !cfg_req_o);
  assert_no_early_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !cfg_rsp_i) |=> !io_ready_o && !cfg_req_o);
  assert_req_enabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> sel_i.en);
  assert_fields_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !cfg_rsp_i) |=>
      $stable({cfg_type1_o, cfg_bus_o, cfg_dev_o, cfg_fn_o, cfg_reg_o,
               cfg_we_o, cfg_be_o, cfg_wdata_o}));
  assert_type_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (cfg_type1_o == (cfg_bus_o != '0)));
  assert_master_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && cfg_rsp_i && !cfg_claimed_i && !cfg_we_o) |=>
      io_ready_o && io_rdata_o == ALL_ONES);
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_port_pkg::*;
#(
  parameter int unsigned      IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_req_i,
  input  logic             io_we_i,
  input  logic [IO_AW-3:0] io_dw_addr_i,
  input  logic [3:0]       io_be_i,
  input  logic [31:0]      io_wdata_i,
  output logic             io_ready_o,
  output logic [31:0]      io_rdata_o,
  output logic             cfg_req_o,
  output logic             cfg_type1_o,
  output logic [7:0]       cfg_bus_o,
  output logic [4:0]       cfg_dev_o,
  output logic [2:0]       cfg_fn_o,
  output logic [5:0]       cfg_reg_o,
  output logic             cfg_we_o,
  output logic [3:0]       cfg_be_o,
  output logic [31:0]      cfg_wdata_o,
  input  logic             cfg_rsp_i,
  input  logic             cfg_claimed_i,
  input  logic [31:0]      cfg_rdata_i
);
  cfg_sel_t      sel;
  logic [DW-1:0] sel_word;
  logic          sel_wr;

  cfg_addr_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sel_wr),
    .be_i    (io_be_i),
    .wdata_i (io_wdata_i),
    .word_o  (sel_word),
    .sel_o   (sel)
  );

  cfg_port_fsm #(
    .IO_AW     (IO_AW),
    .ADDR_PORT (ADDR_PORT),
    .DATA_PORT (DATA_PORT)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .io_req_i      (io_req_i),
    .io_we_i       (io_we_i),
    .io_dw_addr_i  (io_dw_addr_i),
    .io_be_i       (io_be_i),
    .io_wdata_i    (io_wdata_i),
    .io_ready_o    (io_ready_o),
    .io_rdata_o    (io_rdata_o),
    .sel_i         (sel),
    .sel_word_i    (sel_word),
    .sel_wr_o      (sel_wr),
    .cfg_req_o     (cfg_req_o),
    .cfg_type1_o   (cfg_type1_o),
    .cfg_bus_o     (cfg_bus_o),
    .cfg_dev_o     (cfg_dev_o),
    .cfg_fn_o      (cfg_fn_o),
    .cfg_reg_o     (cfg_reg_o),
    .cfg_we_o      (cfg_we_o),
    .cfg_be_o      (cfg_be_o),
    .cfg_wdata_o   (cfg_wdata_o),
    .cfg_rsp_i     (cfg_rsp_i),
    .cfg_claimed_i (cfg_claimed_i),
    .cfg_rdata_i   (cfg_rdata_i)
  );

  assert_ready_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ready_o |=> !io_ready_o);
endmodule

// File: tb/cfg_port_bridge_test.sv
`timescale 1ns/1ps
module cfg_port_bridge_test;
  localparam logic [13:0] A_PORT = 14'(16'hCF8 >> 2);
  localparam logic [13:0] D_PORT = 14'(16'hCFC >> 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_req = 0, io_we = 0;
  logic [13:0] io_addr = '0;
  logic [3:0] io_be = '0;
  logic [31:0] io_wdata = '0;
  logic io_ready;
  logic [31:0] io_rdata;
  logic cfg_req, cfg_type1, cfg_we;
  logic [7:0] cfg_bus;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_fn;
  logic [5:0] cfg_reg;
  logic [3:0] cfg_be;
  logic [31:0] cfg_wdata;
  logic cfg_rsp = 0, cfg_claimed = 0;
  logic [31:0] cfg_rdata = '0;

  int checks = 0, failures = 0, req_cnt = 0;
  logic [31:0] exp_data_q[$];
  string       exp_tag_q[$];
  logic [63:0] exp_req_q[$];
  string       exp_rtag_q[$];

  always #2.5 clk = ~clk;

  cfg_port_bridge uut (
    .clk_i(clk), .rst_ni(rst_n), .io_req_i(io_req), .io_we_i(io_we),
    .io_dw_addr_i(io_addr), .io_be_i(io_be), .io_wdata_i(io_wdata),
    .io_ready_o(io_ready), .io_rdata_o(io_rdata), .cfg_req_o(cfg_req),
    .cfg_type1_o(cfg_type1), .cfg_bus_o(cfg_bus), .cfg_dev_o(cfg_dev),
    .cfg_fn_o(cfg_fn), .cfg_reg_o(cfg_reg), .cfg_we_o(cfg_we),
    .cfg_be_o(cfg_be), .cfg_wdata_o(cfg_wdata), .cfg_rsp_i(cfg_rsp),
    .cfg_claimed_i(cfg_claimed), .cfg_rdata_i(cfg_rdata));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sel_word(logic en, logic [7:0] b, logic [4:0] d,
                                           logic [2:0] f, logic [5:0] r);
    return {en, 7'b0, b, d, f, r, 2'b00};
  endfunction

  // target model: claims every device except 31
  function automatic logic [31:0] tgt_data(logic [7:0] b, logic [4:0] d,
                                           logic [2:0] f, logic [5:0] r);
    return {8'h5A, b, d, f, r, 2'b11};
  endfunction

  function automatic logic [63:0] pack_req(logic t1, logic [7:0] b, logic [4:0] d,
      logic [2:0] f, logic [5:0] r, logic we, logic [3:0] be, logic [31:0] wd);
    return {6'b0, t1, b, d, f, r, we, be, wd};
  endfunction

  task automatic io_acc(logic we, logic [13:0] a, logic [3:0] be, logic [31:0] wd,
                        logic [31:0] exp, string tag);
    exp_data_q.push_back(exp);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    io_req = 1; io_we = we; io_addr = a; io_be = be; io_wdata = wd;
    do @(negedge clk); while (!io_ready);
    io_req = 0;
  endtask

  task automatic cfg_acc(logic we, logic [3:0] be, logic [31:0] wd, logic [7:0] b,
      logic [4:0] d, logic [2:0] f, logic [5:0] r, string tag);
    logic [31:0] exp;
    io_acc(1, A_PORT, 4'hF, sel_word(1, b, d, f, r), 32'h0, {tag, " sel"});
    exp_req_q.push_back(pack_req(b != 0, b, d, f, r, we, be, wd));
    exp_rtag_q.push_back(tag);
    exp = we ? 32'h0 : (d == 5'd31 ? 32'hFFFF_FFFF : tgt_data(b, d, f, r));
    io_acc(we, D_PORT, be, wd, exp, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n && io_ready) begin
    if (exp_data_q.size() == 0) check("R8 unexpected completion", 64'd1, 64'd0);
    else check(exp_tag_q.pop_front(), {32'h0, io_rdata}, {32'h0, exp_data_q.pop_front()});
  end

  // configuration target
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cfg_req) begin
        int lat;
        req_cnt++;
        lat = 1 + (req_cnt % 4);
        if (exp_req_q.size() == 0) check("R7 unexpected request", 64'd1, 64'd0);
        else check({"R3 R4 R5 req ", exp_rtag_q.pop_front()},
                   pack_req(cfg_type1, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_we, cfg_be, cfg_wdata),
                   exp_req_q.pop_front());
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          check("R8 held while waiting", {62'b0, io_ready, cfg_req}, 64'd0);
        end
        cfg_rsp = 1;
        cfg_claimed = cfg_dev != 5'd31;
        cfg_rdata = cfg_claimed ? tgt_data(cfg_bus, cfg_dev, cfg_fn, cfg_reg) : 32'h1234_5678;
        @(negedge clk);
        cfg_rsp = 0; cfg_claimed = 0; cfg_rdata = '0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {62'b0, io_ready, cfg_req}, 64'd0);
    rst_n = 1;
    io_acc(0, A_PORT, 4'hF, 0, 32'h0, "R1 reset selector");
    io_acc(1, A_PORT, 4'hF, 32'hFFFF_FFFF, 0, "R1 write ones");
    io_acc(0, A_PORT, 4'hF, 0, 32'h80FF_FFFC, "R1 readback masked");
    io_acc(1, A_PORT, 4'b0001, 32'h0, 0, "R2 byte0 write");
    io_acc(0, A_PORT, 4'hF, 0, 32'h80FF_FF00, "R2 byte lane merge");
    io_acc(1, A_PORT, 4'b1000, 32'h0, 0, "R2 byte3 write");
    io_acc(0, A_PORT, 4'hF, 0, 32'h00FF_FF00, "R2 enable cleared");
    n = req_cnt;
    io_acc(0, D_PORT, 4'hF, 0, 32'hFFFF_FFFF, "R7 disabled read");
    io_acc(1, D_PORT, 4'hF, 32'hCAFE_F00D, 0, "R7 disabled write");
    repeat (3) @(negedge clk);
    check("R7 no request issued", req_cnt, n);
    cfg_acc(0, 4'hF, 0, 8'h00, 5'd3, 3'd1, 6'd5, "R3 R4 R5 local read");
    cfg_acc(0, 4'hF, 0, 8'h12, 5'd7, 3'd2, 6'h3F, "R4 forwarded read");
    cfg_acc(1, 4'hF, 32'hDEAD_BEEF, 8'h00, 5'd0, 3'd0, 6'd1, "R5 full write");
    cfg_acc(1, 4'b0100, 32'h00AB_0000, 8'h01, 5'd2, 3'd7, 6'd4, "R5 byte lane write");
    cfg_acc(0, 4'b0011, 0, 8'h00, 5'd31, 3'd0, 6'd0, "R6 master abort local");
    cfg_acc(0, 4'hF, 0, 8'hFF, 5'd31, 3'd7, 6'h3F, "R6 master abort forwarded");
    io_acc(0, A_PORT, 4'hF, 0, sel_word(1, 8'hFF, 5'd31, 3'd7, 6'h3F), "R1 readback after use");
    n = req_cnt;
    io_acc(0, 14'h0020, 4'hF, 0, 32'hFFFF_FFFF, "R9 other port read");
    io_acc(1, 14'h0020, 4'hF, 32'h0, 0, "R9 other port write");
    io_acc(1, 14'(16'hCF4 >> 2), 4'hF, 32'h0, 0, "R9 neighbour write");
    io_acc(0, A_PORT, 4'hF, 0, sel_word(1, 8'hFF, 5'd31, 3'd7, 6'h3F), "R9 selector unchanged");
    check("R9 no request issued", req_cnt, n);
    repeat (4) @(negedge clk);
    check("R8 scoreboard drained", exp_data_q.size() + exp_req_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule